// File: doc/BRIEF.md
# Saturating 40-bit Logic and Arithmetic Unit

This block is the arithmetic and logic stage of one datapath side. Each cycle it can accept one operation on two operands. The operands are read as 32-bit words, as 40-bit accumulator values, or as pairs of independent 16-bit halfwords. Add and subtract can either wrap or saturate. The other operations are signed and unsigned compares, bitwise AND/OR/XOR and absolute value. A compare returns its answer as a value in the result rather than in a condition flag.

The only status the unit keeps is a sticky saturation flag. Any saturating operation that has to clamp sets it, and only an explicit clear input resets it. An operation takes effect only when its predicate input is true. A predicated-off operation changes neither the result register nor the flag. The result is registered and appears one cycle after issue, together with a valid strobe.

Top module: `sat_alu40`

## Requirements
- R1: Opcodes 0 (add), 1 (saturating add), 2 (subtract) and 3 (saturating subtract) work on the low 32 bits of both sources as signed words. The plain forms wrap modulo 2^32. The saturating forms clamp to 0x7FFFFFFF or 0x80000000. Bits 39:32 of the result are zero.
- R2: Opcodes 4 (add), 5 (saturating add), 6 (subtract) and 7 (saturating subtract) work on the full 40-bit signed sources. The plain forms wrap modulo 2^40. The saturating forms clamp to 0x7FFFFFFFFF or 0x8000000000.
- R3: Opcodes 8 (add), 9 (saturating add), 10 (subtract) and 11 (saturating subtract) treat bits 15:0 and bits 31:16 as two independent signed halfword lanes. No carry passes between the lanes. Each saturating lane clamps on its own to 0x7FFF or 0x8000. Bits 39:32 of the result are zero.
- R4: The compares return 1 when true and 0 when false, in the full 40-bit result. They look at the low 32 bits of the sources: opcode 12 tests equality, 13 signed greater-than, 14 unsigned greater-than, 15 signed less-than and 16 unsigned less-than.
- R5: Opcodes 17 (AND), 18 (OR) and 19 (XOR) combine the low 32 bits bitwise. Bits 39:32 of the result are zero.
- R6: Opcode 20 returns the absolute value of the signed low 32-bit word, with bits 39:32 zero. Opcode 21 returns the absolute value of the signed 40-bit source. The most negative input of either width gives the most positive value of that width and counts as a clamp.
- R7: sat_flag is set after any executed operation that clamps. It stays set until sat_clr is high at a clock edge. When a clamp and sat_clr occur together, the flag ends up set. Operations that do not clamp never set it.
- R8: When issue is high and pred is low, the operation has no effect. result and sat_flag keep their values (apart from the effect of sat_clr) and result_vld stays low on the next cycle.
- R9: result and result_vld change one clock edge after an issued operation whose predicate is true. Back-to-back operations give back-to-back results.
- R10: After reset, result, result_vld and sat_flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Operation strobe |
| pred | input | 1 | Predicate; the operation executes only when high |
| op | input | 5 | Operation code |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| src_a | input | 40 | First operand |
| src_b | input | 40 | Second operand |
| result | output | 40 | Registered result |
| result_vld | output | 1 | High for one cycle after each executed operation |
| sat_flag | output | 1 | Sticky saturation status |

## Verification
The assertions assume that issue, pred and sat_clr are always known 0/1 levels, and that op stays within the 22 defined codes whenever issue is high. The stimulus meets both by driving every control input from tasks on the falling clock edge, always with an explicit value, and by using only the named codes.

Each of the width modes is exercised at its clamp limits, one step on either side of overflow. The packed mode is fed values that would carry across the lane boundary if the lanes were not independent. The flag is cleared on its own and also cleared in the same cycle as a clamp, and a predicated-off operation is given operands that would otherwise clamp.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD    = 5'd0,
      OP_SADD   = 5'd1,
      OP_SUB    = 5'd2,
      OP_SSUB   = 5'd3,
      OP_ADDL   = 5'd4,
      OP_SADDL  = 5'd5,
      OP_SUBL   = 5'd6,
      OP_SSUBL  = 5'd7,
      OP_ADD2   = 5'd8,
      OP_SADD2  = 5'd9,
      OP_SUB2   = 5'd10,
      OP_SSUB2  = 5'd11,
      OP_CMPEQ  = 5'd12,
      OP_CMPGT  = 5'd13,
      OP_CMPGTU = 5'd14,
      OP_CMPLT  = 5'd15,
      OP_CMPLTU = 5'd16,
      OP_AND    = 5'd17,
      OP_OR     = 5'd18,
      OP_XOR    = 5'd19,
      OP_ABS    = 5'd20,
      OP_ABSL   = 5'd21
   } alu_op_e;

   typedef enum logic [2:0] {
      SEL_W32, SEL_W40, SEL_PACK, SEL_CMP, SEL_LOGIC, SEL_ABS32, SEL_ABS40, SEL_NONE
   } res_sel_e;

   typedef enum logic [2:0] {
      CMP_EQ, CMP_GT, CMP_GTU, CMP_LT, CMP_LTU
   } cmp_kind_e;

   typedef enum logic [1:0] {
      LG_AND, LG_OR, LG_XOR
   } lg_kind_e;

   typedef struct packed {
      res_sel_e  sel;
      logic      sub;
      logic      sat;
      cmp_kind_e cmp;
      lg_kind_e  lg;
   } alu_dec_t;

endpackage

// File: rtl/sat_alu_decode.sv
module sat_alu_decode
   import sat_alu_pkg::*;
(
   input  logic [4:0] op,
   output alu_dec_t   dec
);

   always_comb begin
      dec.sel = SEL_NONE;
      dec.sub = 1'b0;
      dec.sat = 1'b0;
      dec.cmp = CMP_EQ;
      dec.lg  = LG_AND;
      case (op)
         OP_ADD    : dec.sel = SEL_W32;
         OP_SADD   : begin dec.sel = SEL_W32;  dec.sat = 1'b1; end
         OP_SUB    : begin dec.sel = SEL_W32;  dec.sub = 1'b1; end
         OP_SSUB   : begin dec.sel = SEL_W32;  dec.sub = 1'b1; dec.sat = 1'b1; end
         OP_ADDL   : dec.sel = SEL_W40;
         OP_SADDL  : begin dec.sel = SEL_W40;  dec.sat = 1'b1; end
         OP_SUBL   : begin dec.sel = SEL_W40;  dec.sub = 1'b1; end
         OP_SSUBL  : begin dec.sel = SEL_W40;  dec.sub = 1'b1; dec.sat = 1'b1; end
         OP_ADD2   : dec.sel = SEL_PACK;
         OP_SADD2  : begin dec.sel = SEL_PACK; dec.sat = 1'b1; end
         OP_SUB2   : begin dec.sel = SEL_PACK; dec.sub = 1'b1; end
         OP_SSUB2  : begin dec.sel = SEL_PACK; dec.sub = 1'b1; dec.sat = 1'b1; end
         OP_CMPEQ  : begin dec.sel = SEL_CMP;  dec.cmp = CMP_EQ;  end
         OP_CMPGT  : begin dec.sel = SEL_CMP;  dec.cmp = CMP_GT;  end
         OP_CMPGTU : begin dec.sel = SEL_CMP;  dec.cmp = CMP_GTU; end
         OP_CMPLT  : begin dec.sel = SEL_CMP;  dec.cmp = CMP_LT;  end
         OP_CMPLTU : begin dec.sel = SEL_CMP;  dec.cmp = CMP_LTU; end
         OP_AND    : begin dec.sel = SEL_LOGIC; dec.lg = LG_AND; end
         OP_OR     : begin dec.sel = SEL_LOGIC; dec.lg = LG_OR;  end
         OP_XOR    : begin dec.sel = SEL_LOGIC; dec.lg = LG_XOR; end
         OP_ABS    : dec.sel = SEL_ABS32;
         OP_ABSL   : dec.sel = SEL_ABS40;
         default   : dec.sel = SEL_NONE;
      endcase
   end

endmodule

// File: rtl/sat_alu_addsub.sv
module sat_alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         sub,
   input  logic         sat,
   output logic [W-1:0] z,
   output logic         clamped
);

   localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

   logic [W:0] ext;
   logic       ovf;

   always_comb begin
      if (sub) ext = {x[W-1], x} - {y[W-1], y};
      else     ext = {x[W-1], x} + {y[W-1], y};
      ovf     = ext[W] ^ ext[W-1];
      clamped = sat & ovf;
      if (clamped) z = ext[W] ? NEG_LIM : POS_LIM;
      else         z = ext[W-1:0];
   end

   // A clamp can only follow from operands whose effective signs agree
   always_comb begin
      AST_CLAMP_SIGN: assert (!clamped || (x[W-1] == (y[W-1] ^ sub))); // R1
   end

endmodule

// File: rtl/sat_alu_cmplog.sv
module sat_alu_cmplog
   import sat_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  cmp_kind_e    cmp,
   input  lg_kind_e     lg,
   output logic         hit,
   output logic [W-1:0] lz
);

   logic eq, gts, gtu, lts, ltu;

   always_comb begin
      eq  = (x == y);
      gts = ($signed(x) > $signed(y));
      lts = ($signed(x) < $signed(y));
      gtu = (x > y);
      ltu = (x < y);
      case (cmp)
         CMP_GT  : hit = gts;
         CMP_GTU : hit = gtu;
         CMP_LT  : hit = lts;
         CMP_LTU : hit = ltu;
         default : hit = eq;
      endcase
      case (lg)
         LG_OR   : lz = x | y;
         LG_XOR  : lz = x ^ y;
         default : lz = x & y;
      endcase
   end

   always_comb begin
      AST_CMP_EXCL: assert (!(gts && lts) && !(gtu && ltu) && !(eq && (gts || ltu))); // R4
   end

endmodule

// File: rtl/sat_alu40.sv
module sat_alu40
   import sat_alu_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int ACC_W  = 40,
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              pred,
   input  logic [4:0]        op,
   input  logic              sat_clr,
   input  logic [ACC_W-1:0]  src_a,
   input  logic [ACC_W-1:0]  src_b,
   output logic [ACC_W-1:0]  result,
   output logic              result_vld,
   output logic              sat_flag
);

   localparam int LANES = WORD_W / HALF_W;
   localparam int ZX    = ACC_W - WORD_W;

   if (ACC_W <= WORD_W) begin : g_chk_acc
      $error("accumulator width must exceed word width");
   end
   if (LANES * HALF_W != WORD_W) begin : g_chk_lane
      $error("word width must be a whole number of halfwords");
   end

   alu_dec_t dec;
   sat_alu_decode u_dec (.op(op), .dec(dec));

   logic [WORD_W-1:0] a32, b32;
   assign a32 = src_a[WORD_W-1:0];
   assign b32 = src_b[WORD_W-1:0];

   // word and accumulator add/sub
   logic [WORD_W-1:0] w_z;
   logic              w_c;
   sat_alu_addsub #(.W(WORD_W)) u_word (
      .x(a32), .y(b32), .sub(dec.sub), .sat(dec.sat), .z(w_z), .clamped(w_c));

   logic [ACC_W-1:0] l_z;
   logic             l_c;
   sat_alu_addsub #(.W(ACC_W)) u_long (
      .x(src_a), .y(src_b), .sub(dec.sub), .sat(dec.sat), .z(l_z), .clamped(l_c));

   // packed halfword lanes
   logic [WORD_W-1:0] pk_z;
   logic [LANES-1:0]  pk_c;
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sat_alu_addsub #(.W(HALF_W)) u_lane (
         .x(a32[g*HALF_W +: HALF_W]), .y(b32[g*HALF_W +: HALF_W]),
         .sub(dec.sub), .sat(dec.sat),
         .z(pk_z[g*HALF_W +: HALF_W]), .clamped(pk_c[g]));
   end

   // absolute value: saturating negate of negative inputs
   logic [WORD_W-1:0] n32;
   logic              n32_c;
   sat_alu_addsub #(.W(WORD_W)) u_neg32 (
      .x('0), .y(a32), .sub(1'b1), .sat(1'b1), .z(n32), .clamped(n32_c));

   logic [ACC_W-1:0] n40;
   logic             n40_c;
   sat_alu_addsub #(.W(ACC_W)) u_neg40 (
      .x('0), .y(src_a), .sub(1'b1), .sat(1'b1), .z(n40), .clamped(n40_c));

   // compares and bitwise logic
   logic              cmp_hit;
   logic [WORD_W-1:0] lg_z;
   sat_alu_cmplog #(.W(WORD_W)) u_cl (
      .x(a32), .y(b32), .cmp(dec.cmp), .lg(dec.lg), .hit(cmp_hit), .lz(lg_z));

   // result select
   logic [ACC_W-1:0] nxt;
   logic             any_clamp;
   logic             fire;

   assign fire = issue & pred;

   always_comb begin
      nxt       = '0;
      any_clamp = 1'b0;
      case (dec.sel)
         SEL_W32   : begin nxt = {{ZX{1'b0}}, w_z};  any_clamp = w_c;   end
         SEL_W40   : begin nxt = l_z;                any_clamp = l_c;   end
         SEL_PACK  : begin nxt = {{ZX{1'b0}}, pk_z}; any_clamp = |pk_c; end
         SEL_CMP   : nxt = {{(ACC_W-1){1'b0}}, cmp_hit};
         SEL_LOGIC : nxt = {{ZX{1'b0}}, lg_z};
         SEL_ABS32 : begin
            nxt       = {{ZX{1'b0}}, a32[WORD_W-1] ? n32 : a32};
            any_clamp = a32[WORD_W-1] & n32_c;
         end
         SEL_ABS40 : begin
            nxt       = src_a[ACC_W-1] ? n40 : src_a;
            any_clamp = src_a[ACC_W-1] & n40_c;
         end
         default   : nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result     <= '0;
         result_vld <= 1'b0;
         sat_flag   <= 1'b0;
      end else begin
         result_vld <= fire;
         if (fire) result <= nxt;
         sat_flag <= (sat_flag & ~sat_clr) | (fire & any_clamp);
      end
   end

   AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> result_vld); // R9
   AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !result_vld); // R8
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(result)); // R8
   AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !sat_clr) |=> sat_flag); // R7
   AST_SAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_clr && !(fire && any_clamp)) |=> !sat_flag); // R7
   AST_SAT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && any_clamp) |=> sat_flag); // R7
   AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dec.sel == SEL_CMP) |=> (result[ACC_W-1:1] == '0)); // R4
   AST_WORD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (dec.sel == SEL_W32 || dec.sel == SEL_PACK || dec.sel == SEL_LOGIC))
      |=> (result[ACC_W-1:WORD_W] == '0)); // R1

endmodule

// File: tb/sat_alu40_test.sv
module sat_alu40_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        issue, pred, sat_clr;
   logic [4:0]  op;
   logic [39:0] src_a, src_b;
   logic [39:0] result;
   logic        result_vld, sat_flag;

   always #10 clk = ~clk;

   sat_alu40 uut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .pred(pred), .op(op),
      .sat_clr(sat_clr), .src_a(src_a), .src_b(src_b),
      .result(result), .result_vld(result_vld), .sat_flag(sat_flag));

   typedef struct {
      logic        vld;
      logic [39:0] res;
      logic        sat;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          fails  = 0;
   logic [39:0] last_res = '0;
   logic        sat_m = 1'b0;

   // reference model built from the requirement text
   function automatic void model(input logic [4:0] o, input logic [39:0] a,
                                 input logic [39:0] b,
                                 output logic [39:0] r, output logic c);
      longint sa, sb_, s;
      r = '0; c = 1'b0;
      if (o <= 3) begin
         sa = longint'($signed(a[31:0])); sb_ = longint'($signed(b[31:0]));
         s  = (o >= 2) ? sa - sb_ : sa + sb_;
         if ((o == 1 || o == 3) && s > 64'sd2147483647) begin r = 40'h007FFFFFFF; c = 1; end
         else if ((o == 1 || o == 3) && s < -64'sd2147483648) begin r = 40'h0080000000; c = 1; end
         else r = {8'h00, s[31:0]};
      end else if (o <= 7) begin
         sa = longint'($signed(a)); sb_ = longint'($signed(b));
         s  = (o >= 6) ? sa - sb_ : sa + sb_;
         if ((o == 5 || o == 7) && s > 64'sd549755813887) begin r = 40'h7FFFFFFFFF; c = 1; end
         else if ((o == 5 || o == 7) && s < -64'sd549755813888) begin r = 40'h8000000000; c = 1; end
         else r = s[39:0];
      end else if (o <= 11) begin
         for (int h = 0; h < 2; h++) begin
            sa = longint'($signed(a[h*16 +: 16])); sb_ = longint'($signed(b[h*16 +: 16]));
            s  = (o >= 10) ? sa - sb_ : sa + sb_;
            if ((o == 9 || o == 11) && s > 32767) begin r[h*16 +: 16] = 16'h7FFF; c = 1; end
            else if ((o == 9 || o == 11) && s < -32768) begin r[h*16 +: 16] = 16'h8000; c = 1; end
            else r[h*16 +: 16] = s[15:0];
         end
      end else if (o == 12) r = {39'd0, a[31:0] == b[31:0]};
      else if (o == 13) r = {39'd0, $signed(a[31:0]) > $signed(b[31:0])};
      else if (o == 14) r = {39'd0, a[31:0] > b[31:0]};
      else if (o == 15) r = {39'd0, $signed(a[31:0]) < $signed(b[31:0])};
      else if (o == 16) r = {39'd0, a[31:0] < b[31:0]};
      else if (o == 17) r = {8'h00, a[31:0] & b[31:0]};
      else if (o == 18) r = {8'h00, a[31:0] | b[31:0]};
      else if (o == 19) r = {8'h00, a[31:0] ^ b[31:0]};
      else if (o == 20) begin
         sa = longint'($signed(a[31:0]));
         if (sa < 0) sa = -sa;
         if (sa > 64'sd2147483647) begin r = 40'h007FFFFFFF; c = 1; end
         else r = {8'h00, sa[31:0]};
      end else if (o == 21) begin
         sa = longint'($signed(a));
         if (sa < 0) sa = -sa;
         if (sa > 64'sd549755813887) begin r = 40'h7FFFFFFFFF; c = 1; end
         else r = sa[39:0];
      end
   endfunction

   task automatic go(input logic [4:0] o, input logic [39:0] a, input logic [39:0] b,
                     input logic p, input logic clr, input string tag);
      logic [39:0] r;
      logic        c;
      exp_t        e;
      @(negedge clk);
      issue = 1'b1; pred = p; op = o; src_a = a; src_b = b; sat_clr = clr;
      model(o, a, b, r, c);
      sat_m = sat_m & ~clr;
      if (p) begin
         sat_m    = sat_m | c;
         last_res = r;
      end
      e.vld = p; e.res = last_res; e.sat = sat_m; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input logic clr, input string tag);
      exp_t e;
      @(negedge clk);
      issue = 1'b0; pred = 1'b0; op = '0; src_a = '0; src_b = '0; sat_clr = clr;
      sat_m = sat_m & ~clr;
      e.vld = 1'b0; e.res = last_res; e.sat = sat_m; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: one scoreboard item per clock, checked mid-cycle
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (result_vld !== e.vld || result !== e.res || sat_flag !== e.sat) begin
               fails++;
               $display("FAIL %s: actual vld=%0b res=%h sat=%0b expected vld=%0b res=%h sat=%0b",
                        e.tag, result_vld, result, sat_flag, e.vld, e.res, e.sat);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R9: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; issue = 1'b0; pred = 1'b0; op = '0; sat_clr = 1'b0;
      src_a = '0; src_b = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      checks++;
      if (result !== '0 || result_vld !== 1'b0 || sat_flag !== 1'b0) begin
         fails++;
         $display("FAIL R10 reset: actual res=%h vld=%0b sat=%0b expected 0 0 0",
                  result, result_vld, sat_flag);
      end

      // R1 word add/sub
      go(5'd0, 40'hFF7FFFFFFF, 40'h0000000001, 1, 0, "R1 wrap add");
      go(5'd2, 40'h0000000005, 40'h0000000007, 1, 0, "R1 wrap sub");
      go(5'd1, 40'h007FFFFFFF, 40'h0000000001, 1, 0, "R1 sat add clamp");
      idle(1, "R7 clear alone");
      go(5'd3, 40'h0080000000, 40'h0000000001, 1, 0, "R1 sat sub clamp");
      go(5'd1, 40'h0000001000, 40'h0000000234, 1, 1, "R7 clear with no clamp");
      // R2 accumulator width
      go(5'd4, 40'h7FFFFFFFFF, 40'h0000000001, 1, 0, "R2 wrap add");
      go(5'd5, 40'h00FFFFFFFF, 40'h0000000001, 1, 0, "R2 sat add past 32 bits");
      go(5'd5, 40'h7FFFFFFFFF, 40'h0000000001, 1, 0, "R2 sat add clamp");
      go(5'd7, 40'h8000000000, 40'h0000000001, 1, 1, "R7 clamp wins over clear");
      go(5'd6, 40'h0000000000, 40'h0000000001, 1, 1, "R2 wrap sub");
      // R3 packed lanes
      go(5'd8,  40'h007FFFFFFF, 40'h0000010001, 1, 0, "R3 lane wrap no carry");
      go(5'd9,  40'h007FFFFFFF, 40'h0000010001, 1, 0, "R3 lane sat");
      go(5'd11, 40'h0080000005, 40'h0000010007, 1, 1, "R3 lane sat sub");
      go(5'd10, 40'h0000030002, 40'h0000010004, 1, 1, "R3 lane wrap sub");
      // R4 compares
      go(5'd13, 40'h00FFFFFFFF, 40'h0000000001, 1, 0, "R4 signed gt");
      go(5'd14, 40'h00FFFFFFFF, 40'h0000000001, 1, 0, "R4 unsigned gt");
      go(5'd15, 40'h00FFFFFFFF, 40'h0000000001, 1, 0, "R4 signed lt");
      go(5'd16, 40'h00FFFFFFFF, 40'h0000000001, 1, 0, "R4 unsigned lt");
      go(5'd12, 40'hAB12345678, 40'h0012345678, 1, 0, "R4 equal");
      go(5'd12, 40'h0012345678, 40'h0012345679, 1, 0, "R4 not equal");
      // R5 logic
      go(5'd17, 40'hFFF0F0F0F0, 40'h00FF00FF00, 1, 0, "R5 and");
      go(5'd18, 40'hFFF0F0F0F0, 40'h00FF00FF00, 1, 0, "R5 or");
      go(5'd19, 40'hFFF0F0F0F0, 40'h00FF00FF00, 1, 0, "R5 xor");
      // R6 absolute value
      go(5'd20, 40'h00FFFFFFFB, 40'h0, 1, 0, "R6 abs negative");
      go(5'd20, 40'h0000000003, 40'h0, 1, 0, "R6 abs positive");
      go(5'd20, 40'h0080000000, 40'h0, 1, 0, "R6 abs word min");
      idle(1, "R7 clear before abs40");
      go(5'd21, 40'h8000000000, 40'h0, 1, 0, "R6 abs long min");
      go(5'd21, 40'hFF00000000, 40'h0, 1, 1, "R6 abs long negative");
      // R8 predicated off
      go(5'd1, 40'h007FFFFFFF, 40'h0000000001, 0, 0, "R8 pred off no clamp");
      go(5'd17, 40'h00FFFFFFFF, 40'h00FFFFFFFF, 0, 0, "R8 pred off hold");
      idle(0, "R8 idle hold");
      // R9 back to back
      go(5'd0, 40'h1, 40'h2, 1, 0, "R9 back to back a");
      go(5'd0, 40'h3, 40'h4, 1, 0, "R9 back to back b");
      idle(0, "R9 vld drops");
      idle(0, "R9 idle");

      while (sb.size() != 0) @(posedge clk);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule